// File: doc/BRIEF.md
# Clock Pulse Count Command Guard

This block sits between the serial command decoder of a small serial-programmed memory and its program controller. It protects stored data against noise on the serial clock. From the moment a start bit is recognised until chip select falls, it counts serial clock rising edges. When a programming command ends, it compares that count with the exact frame length the command should have in the active organisation. A spurious extra clock pulse shifts every following address and data bit by one position. The guard therefore refuses any programming frame whose length is not exact, so that a shifted frame never reaches the array.

Its inputs are single-cycle event pulses already synchronised to the system clock: start bit seen, serial clock rose, and chip select fell. It also takes the decoded command kind and the organisation select. At the end of each started frame it gives a one-cycle verdict: permit or reject. Commands that do not program the array are always permitted without a length check.

Top module: `cpg_clk_guard`

## Requirements
- R1: After reset, both exec_permit and exec_reject are low, and no frame is open.
- R2: A start_seen pulse opens a frame and sets the count to 1. Each later sck_rise pulse adds 1. An sck_rise pulse in the same cycle as cs_fall is counted. A new start_seen pulse inside an open frame restarts the count at 1.
- R3: For a word write (instr_kind 3'd1) with org_wide=0, a count of exactly 18 is permitted.
- R4: For a word write with org_wide=1, a count of exactly 25 is permitted.
- R5: For a single erase (3'd2) or a full erase (3'd3), the exact length is 10 when org_wide=0 and 9 when org_wide=1.
- R6: A fill-all write (3'd4) needs the same exact length as a word write in the same organisation.
- R7: For a programming command (codes 3'd1 to 3'd4), any other count gives exec_reject and no exec_permit.
- R8: Codes 3'd0 (read), 3'd5 (write enable), 3'd6 (write disable) and 3'd7 are permitted at every count.
- R9: The count saturates at 31 (CNT_W=5) and does not wrap. A 50-pulse word write in 8-bit organisation is rejected.
- R10: The verdict is a single-cycle pulse in the cycle after the cs_fall pulse that closes an open frame. Permit and reject are never high together. The count then clears.
- R11: A cs_fall pulse with no open frame gives neither permit nor reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_seen | input | 1 | Start bit recognised (one-cycle pulse) |
| sck_rise | input | 1 | Serial clock rising edge event (one-cycle pulse) |
| cs_fall | input | 1 | Chip select falling edge event (one-cycle pulse) |
| instr_kind | input | 3 | Decoded command kind, sampled with cs_fall |
| org_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| exec_permit | output | 1 | One-cycle permission to execute |
| exec_reject | output | 1 | One-cycle rejection of a mis-framed command |

## Verification
The bench builds the block with its default parameters: a 5-bit counter, 2 opcode bits, 7/6 address bits and 8/16 data bits. At these values the whole space can be swept. That sweep covers all eight command codes, both organisations and every frame length from 1 to 40 pulses. The reach past 31 exercises saturation. A 50-pulse frame would alias to 18 if the counter wrapped, so it shows whether the counter saturates. Directed frames cover a clock edge that coincides with chip select falling, a restarted frame, and a chip select fall with no open frame.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

   typedef enum logic [2:0] {
      CMD_READ      = 3'd0,
      CMD_WRITE     = 3'd1,
      CMD_ERASE     = 3'd2,
      CMD_ERASE_ALL = 3'd3,
      CMD_FILL_ALL  = 3'd4,
      CMD_WR_EN     = 3'd5,
      CMD_WR_DIS    = 3'd6,
      CMD_SPARE     = 3'd7
   } cmd_kind_e;

   typedef enum logic [1:0] {
      LEN_NONE  = 2'd0,
      LEN_SHORT = 2'd1,
      LEN_LONG  = 2'd2
   } len_class_e;

   function automatic len_class_e classify(input logic [2:0] kind);
      case (kind)
         CMD_WRITE, CMD_FILL_ALL:     classify = LEN_LONG;
         CMD_ERASE, CMD_ERASE_ALL:    classify = LEN_SHORT;
         default:                     classify = LEN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cpg_len_table.sv
module cpg_len_table
   import cpg_pkg::*;
#(
   parameter int OPC_BITS  = 2,
   parameter int ADDR_NARROW = 7,
   parameter int ADDR_WIDE   = 6,
   parameter int DATA_NARROW = 8,
   parameter int DATA_WIDE   = 16,
   parameter int CNT_W       = 5
) (
   input  logic [2:0]       kind,
   input  logic             org_wide,
   output logic             need_check,
   output logic [CNT_W-1:0] exp_len
);

   logic [CNT_W-1:0] short_len [2];
   logic [CNT_W-1:0] long_len  [2];

   for (genvar o = 0; o < 2; o++) begin : g_org
      localparam int ADDR_B = (o == 1) ? ADDR_WIDE : ADDR_NARROW;
      localparam int DATA_B = (o == 1) ? DATA_WIDE : DATA_NARROW;
      localparam int SHORT  = 1 + OPC_BITS + ADDR_B;
      localparam int LONG   = SHORT + DATA_B;
      assign short_len[o] = CNT_W'(SHORT);
      assign long_len[o]  = CNT_W'(LONG);
   end

   len_class_e cls;

   always_comb begin
      cls        = classify(kind);
      need_check = (cls != LEN_NONE);
      case (cls)
         LEN_LONG:  exp_len = long_len[org_wide];
         LEN_SHORT: exp_len = short_len[org_wide];
         default:   exp_len = '0;
      endcase
   end

endmodule

// File: rtl/cpg_pulse_counter.sv
module cpg_pulse_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rise,
   input  logic             clear,
   output logic             armed,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nx
);

   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   always_comb begin
      if (start)
         cnt_nx = CNT_W'(1);
      else if (rise && armed && cnt_q != SAT)
         cnt_nx = cnt_q + CNT_W'(1);
      else
         cnt_nx = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         armed <= 1'b0;
      end else if (clear && !start) begin
         cnt_q <= '0;
         armed <= 1'b0;
      end else begin
         cnt_q <= cnt_nx;
         armed <= armed | start;
      end
   end

   a_r9_saturate : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt_q == SAT && rise && !start && !clear) |=> cnt_q == SAT);

   a_r2_restart : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (armed && cnt_q == CNT_W'(1)));

   a_r10_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !start) |=> (!armed && cnt_q == '0));

endmodule

// File: rtl/cpg_verdict.sv
module cpg_verdict #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close,
   input  logic             armed,
   input  logic             need_check,
   input  logic [CNT_W-1:0] exp_len,
   input  logic [CNT_W-1:0] final_cnt,
   output logic             permit,
   output logic             reject
);

   logic good;

   always_comb good = !need_check || (final_cnt == exp_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         permit <= 1'b0;
         reject <= 1'b0;
      end else begin
         permit <= close && armed && good;
         reject <= close && armed && !good;
      end
   end

   a_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({permit, reject}));

   a_r10_after_close : assert property (@(posedge clk) disable iff (!rst_n)
      (permit || reject) |-> $past(close && armed));

   a_r11_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (close && !armed) |=> !(permit || reject));

   a_r8_bypass : assert property (@(posedge clk) disable iff (!rst_n)
      (close && armed && !need_check) |=> permit);

endmodule

// File: rtl/cpg_clk_guard.sv
module cpg_clk_guard #(
   parameter int OPC_BITS    = 2,
   parameter int ADDR_NARROW = 7,
   parameter int ADDR_WIDE   = 6,
   parameter int DATA_NARROW = 8,
   parameter int DATA_WIDE   = 16,
   parameter int CNT_W       = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_seen,
   input  logic       sck_rise,
   input  logic       cs_fall,
   input  logic [2:0] instr_kind,
   input  logic       org_wide,
   output logic       exec_permit,
   output logic       exec_reject
);

   localparam int LONG_N  = 1 + OPC_BITS + ADDR_NARROW + DATA_NARROW;
   localparam int LONG_W  = 1 + OPC_BITS + ADDR_WIDE + DATA_WIDE;
   localparam int MAX_LEN = (LONG_N > LONG_W) ? LONG_N : LONG_W;
   localparam int SAT     = (1 << CNT_W) - 1;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("cpg_clk_guard: CNT_W out of range");
   end
   if (MAX_LEN >= SAT) begin : g_bad_sat
      $error("cpg_clk_guard: counter too narrow, saturation would hit a legal length");
   end
   if (OPC_BITS < 1 || ADDR_NARROW < 1 || ADDR_WIDE < 1) begin : g_bad_fields
      $error("cpg_clk_guard: field widths must be positive");
   end

   logic             armed;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             need_check;
   logic [CNT_W-1:0] exp_len;

   cpg_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_seen),
      .rise   (sck_rise),
      .clear  (cs_fall),
      .armed  (armed),
      .cnt_q  (cnt_q),
      .cnt_nx (cnt_nx)
   );

   cpg_len_table #(
      .OPC_BITS    (OPC_BITS),
      .ADDR_NARROW (ADDR_NARROW),
      .ADDR_WIDE   (ADDR_WIDE),
      .DATA_NARROW (DATA_NARROW),
      .DATA_WIDE   (DATA_WIDE),
      .CNT_W       (CNT_W)
   ) u_len (
      .kind       (instr_kind),
      .org_wide   (org_wide),
      .need_check (need_check),
      .exp_len    (exp_len)
   );

   cpg_verdict #(.CNT_W(CNT_W)) u_vd (
      .clk        (clk),
      .rst_n      (rst_n),
      .close      (cs_fall),
      .armed      (armed),
      .need_check (need_check),
      .exp_len    (exp_len),
      .final_cnt  (cnt_nx),
      .permit     (exec_permit),
      .reject     (exec_reject)
   );

   a_r1_reset_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !(exec_permit || exec_reject));

endmodule

// File: tb/cpg_clk_guard_bench.sv
module cpg_clk_guard_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_seen = 1'b0;
   logic       sck_rise = 1'b0;
   logic       cs_fall = 1'b0;
   logic [2:0] instr_kind = 3'd0;
   logic       org_wide = 1'b0;
   logic       exec_permit;
   logic       exec_reject;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cpg_clk_guard u_cpg_clk_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_seen  (start_seen),
      .sck_rise    (sck_rise),
      .cs_fall     (cs_fall),
      .instr_kind  (instr_kind),
      .org_wide    (org_wide),
      .exec_permit (exec_permit),
      .exec_reject (exec_reject)
   );

   task automatic check(input string req, input logic act, input logic exp_v, input string what);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp_v);
      end
   endtask

   function automatic int want_len(input int kind, input bit wide);
      int addr = wide ? 6 : 7;
      int data = wide ? 16 : 8;
      if (kind == 1 || kind == 4) return 1 + 2 + addr + data;
      if (kind == 2 || kind == 3) return 1 + 2 + addr;
      return -1;
   endfunction

   // n = total pulses including the start bit
   task automatic frame(input int kind, input bit wide, input int n, input bit coincide, input string req);
      int eff;
      bit exp_ok;
      @(negedge clk);
      instr_kind = 3'(kind);
      org_wide   = wide;
      start_seen = 1'b1;
      @(negedge clk);
      start_seen = 1'b0;
      for (int i = 1; i < n - (coincide ? 1 : 0); i++) begin
         sck_rise = 1'b1;
         @(negedge clk);
         sck_rise = 1'b0;
         @(negedge clk);
      end
      cs_fall  = 1'b1;
      sck_rise = coincide;
      @(negedge clk);
      cs_fall  = 1'b0;
      sck_rise = 1'b0;
      eff = (n > 31) ? 31 : n;
      exp_ok = (want_len(kind, wide) < 0) || (eff == want_len(kind, wide));
      check(req, exec_permit, exp_ok, $sformatf("permit kind=%0d wide=%0d n=%0d", kind, wide, n));
      check(req, exec_reject, !exp_ok, $sformatf("reject kind=%0d wide=%0d n=%0d", kind, wide, n));
      @(negedge clk);
      check("R10", exec_permit | exec_reject, 1'b0, $sformatf("pulse width kind=%0d n=%0d", kind, n));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", exec_permit, 1'b0, "permit in reset");
      check("R1", exec_reject, 1'b0, "reject in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", exec_permit | exec_reject, 1'b0, "idle after reset");

      // R11: close with no open frame
      cs_fall = 1'b1; instr_kind = 3'd1;
      @(negedge clk);
      cs_fall = 1'b0;
      check("R11", exec_permit | exec_reject, 1'b0, "stray close");

      // Sweep R3 R4 R5 R6 R7 R8 R9 across kinds, orgs, lengths
      for (int k = 0; k < 8; k++)
         for (int w = 0; w < 2; w++)
            for (int n = 1; n <= 40; n++)
               frame(k, w[0], n, 1'b0, (k == 0 || k > 4) ? "R8" : "R7");

      // R9: 50 pulses would alias to 18 on a wrapping counter
      frame(1, 1'b0, 50, 1'b0, "R9");
      frame(4, 1'b0, 50, 1'b0, "R9");
      // R2: coincident clock edge counted
      frame(1, 1'b0, 18, 1'b1, "R2");
      frame(2, 1'b1, 9, 1'b1, "R2");
      frame(1, 1'b1, 26, 1'b1, "R2");
      // R3 R4 R5 R6 named points
      frame(1, 1'b0, 18, 1'b0, "R3");
      frame(1, 1'b1, 25, 1'b0, "R4");
      frame(3, 1'b0, 10, 1'b0, "R5");
      frame(4, 1'b1, 25, 1'b0, "R6");

      // R2: restart inside an open frame
      @(negedge clk);
      instr_kind = 3'd2; org_wide = 1'b1;
      start_seen = 1'b1;
      @(negedge clk);
      start_seen = 1'b0;
      for (int i = 0; i < 5; i++) begin
         sck_rise = 1'b1; @(negedge clk); sck_rise = 1'b0; @(negedge clk);
      end
      start_seen = 1'b1;
      @(negedge clk);
      start_seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
         sck_rise = 1'b1; @(negedge clk); sck_rise = 1'b0; @(negedge clk);
      end
      cs_fall = 1'b1;
      @(negedge clk);
      cs_fall = 1'b0;
      check("R2", exec_permit, 1'b1, "restart permit");
      check("R2", exec_reject, 1'b0, "restart reject");
      @(negedge clk);
      // R10: frame closed, second close is stray
      cs_fall = 1'b1;
      @(negedge clk);
      cs_fall = 1'b0;
      check("R10", exec_permit | exec_reject, 1'b0, "count cleared after verdict");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule